// File: doc/BRIEF.md
# Pad Input Qualification Filter

This block conditions one raw input pin before on-chip logic sees it. The raw level passes through a two-flop synchronizer. A 2-bit mode input then picks one of four views of the pin:

- the synchronized level as it is;
- a debounced level that moves only after three samples in a row disagree with it;
- the same debounced level with a run length of six;
- the raw pin with no clocked stage at all.

A divider sets the spacing of the debounce samples. Its terminal count is an input, so one setting can be shared by every pad in a group. An optional inverter sits at the very end of the path.

The period input gives the number of idle clocks between samples, so a value of N yields one sample every N+1 clocks. A pending run restarts whenever a sample matches the current output level. A change of mode waits for the next sample tick. That tick only adopts the new mode and wipes the run count; it moves no level.

Top module: `pad_qual_filter`

## Requirements
- R1: A synchronous active-high reset clears both synchronizer flops, the run count, the qualified level, the divider count and the active mode (2'b00). With invert at 0, the output reads 0 in the first cycle after reset.
- R2: With mode 2'b00 active, the output equals the pad value registered at the second clock edge before, regardless of the period input.
- R3: With mode 2'b01 active, the output level changes only on the sample tick at which the third consecutive synchronized sample differs from it.
- R4: With mode 2'b10 active, the output level changes only on the sample tick at which the sixth consecutive differing sample is taken.
- R5: With mode 2'b11 active, the output follows the pad input combinationally, with no clock delay.
- R6: A sample tick occurs every clock when the period input is 0, and once every N+1 clocks when it is N. The divider starts counting from 0 after reset.
- R7: In the filtered modes, a sample equal to the current output level sets the run count back to zero, so an earlier partial run cannot contribute.
- R8: A new mode value becomes active at the next sample tick. That tick clears the run count and leaves the filtered level unchanged.
- R9: Invert select 1 complements the selected result in all four modes, asynchronous included; invert select 0 leaves it unchanged.
- R10: While mode 2'b00 or 2'b11 is active, every sample tick loads the synchronized sample into the filtered level. Entering a filtered mode therefore starts from the current pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Qualifier clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_raw | input | 1 | Raw level from the pad |
| qual_mode | input | 2 | 00 sync, 01 three-sample, 10 six-sample, 11 async |
| inv_sel | input | 1 | 1 inverts the delivered level |
| sample_period | input | PERIOD_W | Idle clocks between samples (group setting) |
| pad_qual | output | 1 | Conditioned level delivered to the chip |

## Verification
The hardest case to reach from the ports is a mode change that lands while a partial run is pending. A stale count must not carry a level across that boundary. The stimulus builds a two-sample run in three-sample mode with a non-zero period, then switches to six-sample mode just before the tick that would have completed the run. A long pseudo-random phase then changes pad, mode, period and invert against each other, so mode switches fall at every offset within the divider period.

// File: rtl/pad_qual_pkg.sv
package pad_qual_pkg;

    typedef enum logic [1:0] {
        QM_SYNC  = 2'b00,
        QM_Q3    = 2'b01,
        QM_Q6    = 2'b10,
        QM_ASYNC = 2'b11
    } qual_mode_e;

    localparam int unsigned SHORT_RUN = 3;
    localparam int unsigned LONG_RUN  = 6;
    localparam int unsigned RUN_W     = $clog2(LONG_RUN + 1);

    typedef logic [RUN_W-1:0] run_t;

    typedef struct packed {
        qual_mode_e mode;
        logic       level;
        run_t       run;
    } filt_state_t;

    function automatic logic is_filtered(input qual_mode_e m);
        return (m == QM_Q3) || (m == QM_Q6);
    endfunction

    function automatic run_t run_target(input qual_mode_e m);
        return (m == QM_Q6) ? run_t'(LONG_RUN) : run_t'(SHORT_RUN);
    endfunction

endpackage

// File: rtl/pad_qual_sync.sv
module pad_qual_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned WARM_W = $clog2(STAGES + 1);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    // warm-up counter so the delay check never looks back into reset
    logic [WARM_W-1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                      warm <= '0;
        else if (warm != WARM_W'(STAGES)) warm <= warm + 1'b1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            a_r2_two_stage_delay: assert property (@(posedge clk) disable iff (rst)
                (warm == WARM_W'(STAGES)) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/pad_qual_tick.sv
module pad_qual_tick #(
    parameter int unsigned PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    logic [PERIOD_W-1:0] cnt;

    // >= so that lowering the period mid-count wraps at once
    assign tick = (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    a_r6_zero_period_every_clock: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |-> tick);

    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && !$past(rst) && (period != '0) && $stable(period)) |-> !tick);

endmodule

// File: rtl/pad_qual_core.sv
module pad_qual_core
    import pad_qual_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sample,
    input  qual_mode_e mode_req,
    output qual_mode_e mode_act,
    output logic       level
);
    filt_state_t st_q, st_d;
    run_t        target;
    run_t        run_inc;

    assign target  = run_target(st_q.mode);
    assign run_inc = st_q.run + 1'b1;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (mode_req != st_q.mode) begin
                st_d.mode = mode_req;
                st_d.run  = '0;
            end else if (!is_filtered(st_q.mode)) begin
                st_d.level = sample;
                st_d.run   = '0;
            end else if (sample == st_q.level) begin
                st_d.run = '0;
            end else if (run_inc == target) begin
                st_d.level = sample;
                st_d.run   = '0;
            end else begin
                st_d.run = run_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: QM_SYNC, level: 1'b0, run: '0};
        else     st_q <= st_d;
    end

    assign mode_act = st_q.mode;
    assign level    = st_q.level;

    a_r3_level_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (st_q.level != $past(st_q.level)) |-> ($past(tick) && !$past(rst)));

    a_r4_run_below_target: assert property (@(posedge clk) disable iff (rst)
        is_filtered(st_q.mode) |-> (st_q.run < target));

    a_r7_run_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (st_q.run > $past(st_q.run)) |-> (st_q.run == $past(st_q.run) + 1'b1));

    a_r8_switch_holds_level: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && !$past(rst) && ($past(mode_req) != $past(st_q.mode)))
            |-> ((st_q.level == $past(st_q.level)) && (st_q.run == '0)));

endmodule

// File: rtl/pad_qual_filter.sv
module pad_qual_filter
    import pad_qual_pkg::*;
#(
    parameter int unsigned PERIOD_W    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pad_raw,
    input  logic [1:0]          qual_mode,
    input  logic                inv_sel,
    input  logic [PERIOD_W-1:0] sample_period,
    output logic                pad_qual
);
    logic       pad_sync;
    logic       tick;
    logic       filt_level;
    qual_mode_e mode_act;
    logic       selected;

    pad_qual_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_raw),
        .q   (pad_sync)
    );

    pad_qual_tick #(.PERIOD_W(PERIOD_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .period (sample_period),
        .tick   (tick)
    );

    pad_qual_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .sample   (pad_sync),
        .mode_req (qual_mode_e'(qual_mode)),
        .mode_act (mode_act),
        .level    (filt_level)
    );

    always_comb begin
        unique case (mode_act)
            QM_SYNC:  selected = pad_sync;
            QM_ASYNC: selected = pad_raw;
            default:  selected = filt_level;
        endcase
    end

    assign pad_qual = selected ^ inv_sel;

    a_r5_async_follows_pad: assert property (@(posedge clk) disable iff (rst)
        (mode_act == QM_ASYNC) |-> (pad_qual == (pad_raw ^ inv_sel)));

    a_r9_invert_flips_sync: assert property (@(posedge clk) disable iff (rst)
        (mode_act == QM_SYNC) |-> (pad_qual == (pad_sync ^ inv_sel)));

endmodule

// File: tb/pad_qual_filter_tb.sv
module pad_qual_filter_tb;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pad_raw = 1'b0;
    logic [1:0]    qual_mode = 2'b00;
    logic          inv_sel = 1'b0;
    logic [PW-1:0] sample_period = '0;
    logic          pad_qual;

    always #10 clk = ~clk;

    pad_qual_filter #(.PERIOD_W(PW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .pad_raw(pad_raw), .qual_mode(qual_mode),
        .inv_sel(inv_sel), .sample_period(sample_period), .pad_qual(pad_qual)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string tag    = "R1";

    // behavioural reference model
    bit sq[$] = '{1'b0, 1'b0};
    int cnt_m = 0;
    int mode_m = 0;
    bit level_m = 0;
    int run_m = 0;

    always @(posedge clk) begin
        if (rst) begin
            sq = '{1'b0, 1'b0};
            cnt_m = 0; mode_m = 0; level_m = 0; run_m = 0;
        end else begin
            bit smp;
            bit tk;
            int need;
            smp = sq[1];
            tk  = (cnt_m >= int'(sample_period));
            cnt_m = tk ? 0 : cnt_m + 1;
            sq.push_front(pad_raw);
            void'(sq.pop_back());
            if (tk) begin
                need = (mode_m == 2) ? 6 : 3;
                if (int'(qual_mode) != mode_m) begin
                    mode_m = int'(qual_mode);
                    run_m = 0;
                end else if (mode_m == 0 || mode_m == 3) begin
                    level_m = smp; run_m = 0;
                end else if (smp == level_m) begin
                    run_m = 0;
                end else begin
                    run_m++;
                    if (run_m == need) begin
                        level_m = smp; run_m = 0;
                    end
                end
            end
        end
    end

    function automatic bit expect_out();
        bit v;
        if (mode_m == 0)      v = sq[1];
        else if (mode_m == 3) v = pad_raw;
        else                  v = level_m;
        return v ^ inv_sel;
    endfunction

    task automatic cyc();
        bit e;
        @(posedge clk);
        #5;
        e = expect_out();
        checks++;
        if (pad_qual !== e) begin
            fails++;
            $display("FAIL %s: t=%0t mode=%0d got %b expected %b", tag, $time, mode_m, pad_qual, e);
        end
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic hold(input bit v, input int n);
        pad_raw = v;
        run_n(n);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr;
        // R1: reset state
        tag = "R1";
        pad_raw = 1'b1;
        run_n(3);
        rst = 1'b0;
        pad_raw = 1'b0;
        run_n(2);

        // R2: synchronizer pass-through, period ignored
        tag = "R2";
        sample_period = 8'd3;
        hold(1, 3); hold(0, 1); hold(1, 2); hold(0, 4);

        // R3 / R7: three-sample filter, every clock
        tag = "R3";
        sample_period = 8'd0;
        qual_mode = 2'b01;
        run_n(3);
        hold(1, 1); hold(0, 4);
        hold(1, 2); hold(0, 4);
        tag = "R7";
        hold(1, 2); hold(0, 1); hold(1, 2); hold(0, 4);
        tag = "R3";
        hold(1, 6); hold(0, 6);

        // R4 / R6: six-sample filter with period 2
        tag = "R4";
        qual_mode = 2'b10;
        sample_period = 8'd2;
        run_n(4);
        hold(1, 14); hold(0, 3); hold(1, 20);
        tag = "R6";
        hold(0, 25); hold(1, 10); hold(0, 3); hold(1, 30);

        // R5 / R9: asynchronous and invert
        tag = "R5";
        qual_mode = 2'b11;
        run_n(4);
        hold(0, 1); hold(1, 1); hold(0, 2);
        tag = "R9";
        inv_sel = 1'b1;
        hold(1, 2); hold(0, 2);
        qual_mode = 2'b00; run_n(6);
        qual_mode = 2'b01; sample_period = 8'd0; hold(1, 6);
        inv_sel = 1'b0;

        // R10 then R8: tracking in sync mode, switch mid run
        tag = "R10";
        qual_mode = 2'b00;
        hold(0, 6);
        qual_mode = 2'b01;
        run_n(3);
        tag = "R8";
        sample_period = 8'd3;
        run_n(4);
        hold(1, 10);
        qual_mode = 2'b10;
        hold(1, 12);
        hold(1, 20);

        // mixed pseudo-random phase
        tag = "R8";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] < 4'd5) pad_raw = ~pad_raw;
            if (lfsr[11:6] == 6'd0) qual_mode = lfsr[15:14];
            if (lfsr[11:6] == 6'd1) sample_period = 8'(lfsr[14:13]);
            if (lfsr[11:6] == 6'd2) inv_sel = ~inv_sel;
            cyc();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule